// File: doc/BRIEF.md
# Multi-sector erase command sequencer

This block is the command front end of a parallel NOR-flash style memory model. It watches bus writes made with an active-low write strobe. A fixed five-write unlock and setup prefix, followed by a command write, starts either a sector erase or a chip-wide erase. For a sector erase, the sector index comes from the upper address bits of the final write. More sectors join the same operation when the host repeats only that final command write. Every write restarts an acceptance window. The erase begins only when the window runs out with no further write.

The erase itself is abstracted. Selected, unprotected sectors are cleared one at a time, from the lowest index upwards, and each takes a fixed number of clock cycles. A completed sector shows up on a sticky bitmask. A suspend command pauses the work, or ends the acceptance window early. A resume continues from the sector that was interrupted. A ready/busy pin reports activity. Reads made while the block is busy return polling status: bit 7 held low and bit 6 toggling. Reads made while it is not busy return a simplified array view. The bus is strobe-timed, has no valid/ready handshake and applies no back-pressure. The host must space its writes itself.

Top module: `sec_erase_seq`

## Requirements
- R1: The write sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h written to any address starts a sector erase. The unlock addresses are compared on the low ADDR_W-IDX_W address bits. The sector index is the top IDX_W address bits of the final write. ready goes low once this write is accepted.
- R2: Any write that does not match the next expected unlock or setup cycle returns the block to read mode. A following lone 30h write then has no effect: ready stays high and no sector is erased.
- R3: The address of a write is captured on the falling edge of wr_n. The data of a write is captured on the rising edge of wr_n. A change of address while the strobe is low does not change the selected sector.
- R4: While the acceptance window is open, each further 30h write adds the sector of its address. Sectors may be added in any order.
- R5: The acceptance window restarts on every falling edge of wr_n. The window closes WIN_CYC counted cycles after the last rising edge, and the erase then starts.
- R6: After the window has closed, a 30h write adds no sector. All writes other than suspend (B0h) are ignored while the erase runs.
- R7: Sectors are erased one at a time in ascending index order, each in ERASE_CYC cycles. A finished sector sets its bit in erased. At most one bit is set per cycle.
- R8: A suspend (B0h) written during the acceptance window ends the window at once and enters the suspended state. ready is high and nothing is erased until a resume.
- R9: Suspend (B0h) during an erase, and resume (30h written while suspended), may be repeated any number of times. erased is stable while suspended. On resume the work continues with the interrupted sector and keeps the progress it had made.
- R10: Sectors flagged in prot_mask, and sectors that were never selected, are never erased.
- R11: If the sixth write is 10h@555h, it starts a chip-wide erase of all unprotected sectors. A suspend written during a chip-wide erase is ignored and ready stays low.
- R12: A read returns rd_data one cycle after rd_en. While busy, rd_data has bit 7 = 0, bits 5:0 = 0, and bit 6 inverted on every busy read, starting at 1. While not busy, rd_data is FFh for an erased sector and 00h for any other sector.
- R13: After reset, and after an operation completes, ready is high and the block is in read mode. After reset, erased is all zero. Starting a new operation clears erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Write address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | One-cycle read request |
| rd_addr | input | ADDR_W | Read address (sector in the top bits) |
| prot_mask | input | NSEC | Protected sectors, one bit per sector |
| ready | output | 1 | High when idle or suspended, low while busy |
| rd_data | output | 8 | Read result: status while busy, array view otherwise |
| erased | output | NSEC | Sticky mask of sectors erased by the current operation |

## Verification
The sector erase is driven with sectors added out of index order, and with writes spaced to keep the window open well past its nominal length. A scoreboard then shows that the window was restarted and that the erase order is ascending rather than the order of arrival. Further runs separate these cases from one another: a corrupted unlock prefix, an address changed mid-strobe, a 30h written after the window closed, and a suspend inside the window. Repeated suspend and resume with a protected sector in the set shows that progress is kept across a pause and that protected sectors are skipped. A chip-wide erase with a suspend attempt shows that the suspend is ignored in that mode only.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_C1, ST_C2, ST_C3, ST_C4, ST_C5,
    ST_WIN, ST_ERASE, ST_SUSP, ST_CHIP
  } seq_st_t;

  localparam logic [7:0] CMD_KEY_A = 8'hAA;
  localparam logic [7:0] CMD_KEY_B = 8'h55;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;

  localparam logic [10:0] ADR_HI = 11'h555;
  localparam logic [10:0] ADR_LO = 11'h2AA;
endpackage

// File: rtl/cmd_decode.sv
`timescale 1ns/1ps
module cmd_decode #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ev_v,
  output logic [ADDR_W-1:0] ev_a,
  output logic [DATA_W-1:0] ev_d,
  output logic              fall_p,
  output logic              held
);
  logic              wr_q;
  logic [ADDR_W-1:0] a_cap;
  logic              fall_now;
  logic              rise_now;

  assign fall_now = wr_q & ~wr_n;
  assign rise_now = ~wr_q & wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b1;
      a_cap  <= '0;
      ev_v   <= 1'b0;
      ev_a   <= '0;
      ev_d   <= '0;
      fall_p <= 1'b0;
      held   <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      fall_p <= fall_now;
      ev_v   <= rise_now;
      if (fall_now) begin
        a_cap <= addr;
        held  <= 1'b1;
      end
      if (rise_now) begin
        ev_a <= a_cap;
        ev_d <= wdata;
        held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/win_timer.sv
`timescale 1ns/1ps
module win_timer #(
  parameter int WIN_CYC = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && !restart && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/erase_engine.sv
`timescale 1ns/1ps
module erase_engine #(
  parameter int NSEC      = 16,
  parameter int ERASE_CYC = 1000,
  localparam int IDX_W    = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_v,
  input  logic [IDX_W-1:0] add_idx,
  input  logic             add_all,
  input  logic             run,
  input  logic [NSEC-1:0]  prot,
  output logic [NSEC-1:0]  sel,
  output logic [NSEC-1:0]  erased,
  output logic             done
);
  localparam int CNT_W = $clog2(ERASE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ERASE_CYC - 1);

  logic [NSEC-1:0]  work;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [NSEC-1:0]  add_bit;

  assign work    = sel & ~prot;
  assign done    = (work == '0);
  assign add_bit = {{(NSEC-1){1'b0}}, 1'b1} << add_idx;

  always_comb begin
    idx = '0;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (work[i]) idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel    <= '0;
      erased <= '0;
      cnt    <= '0;
    end else if (clr) begin
      erased <= '0;
      cnt    <= '0;
      if (add_all)    sel <= '1;
      else if (add_v) sel <= add_bit;
      else            sel <= '0;
    end else begin
      if (add_v) sel <= sel | add_bit;
      if (run && !done) begin
        if (cnt == LAST) begin
          erased[idx] <= 1'b1;
          sel[idx]    <= 1'b0;
          cnt         <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/status_rd.sv
`timescale 1ns/1ps
module status_rd #(
  parameter int NSEC   = 16,
  localparam int IDX_W = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_sec,
  input  logic             busy,
  input  logic [NSEC-1:0]  erased,
  output logic [7:0]       rd_data
);
  logic tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog     <= 1'b0;
      rd_data <= '0;
    end else if (rd_en) begin
      if (busy) begin
        rd_data <= {1'b0, ~tog, 6'b0};
        tog     <= ~tog;
      end else begin
        rd_data <= erased[rd_sec] ? 8'hFF : 8'h00;
      end
    end
  end
endmodule

// File: rtl/sec_erase_seq.sv
`timescale 1ns/1ps
module sec_erase_seq
  import seq_pkg::*;
#(
  parameter int NSEC      = 16,
  parameter int ADDR_W    = 16,
  parameter int WIN_CYC   = 16000,
  parameter int ERASE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSEC-1:0]   prot_mask,
  output logic              ready,
  output logic [7:0]        rd_data,
  output logic [NSEC-1:0]   erased
);
  localparam int IDX_W = $clog2(NSEC);
  localparam int LOW_W = ADDR_W - IDX_W;

  seq_st_t           st, st_n;
  logic              ev_v, fall_p, held;
  logic [ADDR_W-1:0] ev_a;
  logic [7:0]        ev_d;
  logic              expire, tmr_rst, tmr_run;
  logic              clr, add_v, add_all, run, done;
  logic [NSEC-1:0]   sel;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [10:0] ea,
                               input logic [7:0] d, input logic [7:0] ed);
    return (a[LOW_W-1:0] == LOW_W'(ea)) && (d == ed);
  endfunction

  cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(8)) dec_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .ev_v(ev_v), .ev_a(ev_a), .ev_d(ev_d), .fall_p(fall_p), .held(held)
  );

  assign tmr_run = (st == ST_WIN) && !held;

  win_timer #(.WIN_CYC(WIN_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(tmr_rst), .run(tmr_run), .expire(expire)
  );

  assign run = (st == ST_ERASE) || (st == ST_CHIP);

  erase_engine #(.NSEC(NSEC), .ERASE_CYC(ERASE_CYC)) eng_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .add_v(add_v),
    .add_idx(ev_a[ADDR_W-1 -: IDX_W]), .add_all(add_all), .run(run),
    .prot(prot_mask), .sel(sel), .erased(erased), .done(done)
  );

  assign ready = !((st == ST_WIN) || (st == ST_ERASE) || (st == ST_CHIP));

  status_rd #(.NSEC(NSEC)) rd_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sec(rd_addr[ADDR_W-1 -: IDX_W]),
    .busy(!ready), .erased(erased), .rd_data(rd_data)
  );

  always_comb begin
    st_n    = st;
    clr     = 1'b0;
    add_v   = 1'b0;
    add_all = 1'b0;
    tmr_rst = fall_p;
    case (st)
      ST_READ: if (ev_v && hit(ev_a, ADR_HI, ev_d, CMD_KEY_A)) st_n = ST_C1;
      ST_C1:   if (ev_v) st_n = hit(ev_a, ADR_LO, ev_d, CMD_KEY_B) ? ST_C2 : ST_READ;
      ST_C2:   if (ev_v) st_n = hit(ev_a, ADR_HI, ev_d, CMD_SETUP) ? ST_C3 : ST_READ;
      ST_C3:   if (ev_v) st_n = hit(ev_a, ADR_HI, ev_d, CMD_KEY_A) ? ST_C4 : ST_READ;
      ST_C4:   if (ev_v) st_n = hit(ev_a, ADR_LO, ev_d, CMD_KEY_B) ? ST_C5 : ST_READ;
      ST_C5: begin
        if (ev_v) begin
          if (ev_d == CMD_SECT) begin
            st_n    = ST_WIN;
            clr     = 1'b1;
            add_v   = 1'b1;
            tmr_rst = 1'b1;
          end else if (hit(ev_a, ADR_HI, ev_d, CMD_CHIP)) begin
            st_n    = ST_CHIP;
            clr     = 1'b1;
            add_all = 1'b1;
          end else begin
            st_n = ST_READ;
          end
        end
      end
      ST_WIN: begin
        if (ev_v) begin
          if (ev_d == CMD_SECT) begin
            add_v   = 1'b1;
            tmr_rst = 1'b1;
          end else if (ev_d == CMD_SUSP) begin
            st_n = ST_SUSP;
          end else begin
            st_n = ST_READ;
            clr  = 1'b1;
          end
        end else if (expire) begin
          st_n = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (ev_v && ev_d == CMD_SUSP) st_n = ST_SUSP;
        else if (done)                st_n = ST_READ;
      end
      ST_SUSP: if (ev_v && ev_d == CMD_SECT) st_n = ST_ERASE;
      ST_CHIP: if (done) st_n = ST_READ;
      default: st_n = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_READ;
    else        st <= st_n;
  end
endmodule

// File: rtl/esq_chk.sv
`timescale 1ns/1ps
module esq_chk
  import seq_pkg::*;
#(
  parameter int NSEC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            rd_en,
  input logic [7:0]      rd_data,
  input logic [NSEC-1:0] erased,
  input logic [NSEC-1:0] prot_mask,
  input logic [NSEC-1:0] sel,
  input seq_st_t         st,
  input logic            ev_v,
  input logic [7:0]      ev_d
);
  logic pend, have, last6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      have  <= 1'b0;
      last6 <= 1'b0;
    end else begin
      pend <= rd_en && !ready;
      if (pend) begin
        last6 <= rd_data[6];
        have  <= 1'b1;
      end
    end
  end

  // R12
  poll_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (rd_data[7] == 1'b0 && rd_data[5:0] == 6'b0));

  // R12
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && have) |-> (rd_data[6] != last6));

  // R10
  prot_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(erased & ~$past(erased) & prot_mask)) == 1'b0);

  // R7
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(erased & ~$past(erased)));

  // R9
  susp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_SUSP && st == ST_SUSP) |-> $stable(erased));

  // R6
  no_late_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_ERASE && st == ST_ERASE) |-> ((sel & ~$past(sel)) == '0));

  // R11
  chip_no_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHIP && ev_v && ev_d == CMD_SUSP) |=> (st != ST_SUSP));
endmodule

bind sec_erase_seq esq_chk #(.NSEC(NSEC)) chk_i (.*);

// File: tb/sec_erase_seq_tb_top.sv
`timescale 1ns/1ps
module sec_erase_seq_tb_top;
  localparam int NSEC = 16;
  localparam int ADDR_W = 16;
  localparam int WIN_CYC = 40;
  localparam int ERASE_CYC = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [NSEC-1:0] prot_mask = '0;
  logic ready;
  logic [7:0] rd_data;
  logic [NSEC-1:0] erased;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int exp_q[$];
  logic [NSEC-1:0] prev_er = '0;

  always #2.5 clk = ~clk;

  sec_erase_seq #(.NSEC(NSEC), .ADDR_W(ADDR_W), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .prot_mask(prot_mask),
    .ready(ready), .rd_data(rd_data), .erased(erased)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor: each newly erased sector must match the next expected index
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NSEC-1:0] nb;
      nb = erased & ~prev_er;
      for (int i = 0; i < NSEC; i++) begin
        if (nb[i]) begin
          if (exp_q.size() == 0) begin
            chk(0, "R7 unexpected erase", i, -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk(i == e, "R7 order", i, e);
          end
        end
      end
      prev_er = erased;
    end
  end

  task automatic push_mask(input logic [NSEC-1:0] m);
    for (int i = 0; i < NSEC; i++) if (m[i]) exp_q.push_back(i);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input int sec, input logic [11:0] lo, input logic [7:0] d);
    @(negedge clk);
    addr = {sec[3:0], lo};
    wdata = d;
    wr_n = 1'b0;
    cyc(2);
    wr_n = 1'b1;
    cyc(2);
  endtask

  task automatic unlock5();
    bus_wr(0, 12'h555, 8'hAA);
    bus_wr(0, 12'h2AA, 8'h55);
    bus_wr(0, 12'h555, 8'h80);
    bus_wr(0, 12'h555, 8'hAA);
    bus_wr(0, 12'h2AA, 8'h55);
  endtask

  task automatic rd(input int sec, output logic [7:0] v);
    @(negedge clk);
    rd_addr = {sec[3:0], 12'h000};
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_ready(input int maxc);
    for (int i = 0; i < maxc && !ready; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, v2;
    int n;
    logic [NSEC-1:0] snap;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R13 reset state
    chk(ready == 1'b1, "R13 ready after reset", ready, 1);
    chk(erased == '0, "R13 erased after reset", erased, 0);

    // R2 broken prefix
    bus_wr(0, 12'h555, 8'hAA);
    bus_wr(0, 12'h2AA, 8'h55);
    bus_wr(0, 12'h555, 8'h81);
    bus_wr(0, 12'h555, 8'hAA);
    bus_wr(0, 12'h2AA, 8'h55);
    bus_wr(3, 12'h100, 8'h30);
    cyc(3);
    chk(ready == 1'b1, "R2 ready after bad prefix", ready, 1);
    cyc(150);
    chk(erased == '0, "R2 nothing erased", erased, 0);
    rd(3, v);
    chk(v == 8'h00, "R12 read unerased sector", v, 8'h00);

    // R1 R3 R4 R5 sector erase, added out of order, address moved mid strobe
    push_mask(16'h0224);
    unlock5();
    @(negedge clk);
    addr = {4'd5, 12'h100};
    wdata = 8'h00;
    wr_n = 1'b0;
    @(negedge clk);
    addr = {4'd14, 12'h100};
    @(negedge clk);
    wdata = 8'h30;
    wr_n = 1'b1;
    cyc(2);
    chk(ready == 1'b0, "R1 busy after final write", ready, 0);
    rd(0, v);
    rd(0, v2);
    chk(v[7] == 1'b0 && v2[7] == 1'b0, "R12 poll bit7 low", {v, v2}, 0);
    chk(v[6] != v2[6], "R12 bit6 toggles", {v[6], v2[6]}, 2'b01);
    cyc(20);
    bus_wr(9, 12'h100, 8'h30);
    cyc(25);
    bus_wr(2, 12'h100, 8'h30);
    // R5 window open beyond WIN_CYC from first write: nothing started yet
    cyc(50);
    // R6 late 30h after expiry
    bus_wr(11, 12'h100, 8'h30);
    cyc(6);
    chk(erased == '0, "R5 no sector before window+erase", erased, 0);
    cyc(20);
    chk(erased == 16'h0004, "R5 first sector after window", erased, 16'h0004);
    wait_ready(1000);
    cyc(2);
    chk(ready == 1'b1, "R13 ready after completion", ready, 1);
    chk(erased == 16'h0224, "R4 R6 final mask", erased, 16'h0224);
    rd(5, v);
    chk(v == 8'hFF, "R12 read erased sector", v, 8'hFF);
    rd(14, v);
    chk(v == 8'h00, "R3 moved address not erased", v, 8'h00);

    // R8 suspend inside the window
    unlock5();
    bus_wr(4, 12'h100, 8'h30);
    bus_wr(1, 12'h100, 8'h30);
    bus_wr(0, 12'h000, 8'hB0);
    chk(ready == 1'b1, "R8 ready after suspend in window", ready, 1);
    cyc(200);
    chk(erased == '0, "R8 no erase while suspended", erased, 0);
    push_mask(16'h0012);
    bus_wr(0, 12'h000, 8'h30);
    wait_ready(1000);
    cyc(2);
    chk(erased == 16'h0012, "R8 resumed result", erased, 16'h0012);

    // R9 R10 repeated suspend with a protected sector
    prot_mask = 16'h0040;
    push_mask(16'h1088);
    unlock5();
    bus_wr(12, 12'h100, 8'h30);
    bus_wr(6, 12'h100, 8'h30);
    bus_wr(3, 12'h100, 8'h30);
    bus_wr(7, 12'h100, 8'h30);
    cyc(WIN_CYC + ERASE_CYC + 10);
    bus_wr(0, 12'h000, 8'hB0);
    chk(ready == 1'b1, "R9 ready when suspended", ready, 1);
    snap = erased;
    chk(snap == 16'h0008, "R9 progress at suspend", snap, 16'h0008);
    cyc(150);
    chk(erased == snap, "R9 stable while suspended", erased, snap);
    rd(3, v);
    chk(v == 8'hFF, "R12 read during suspend", v, 8'hFF);
    bus_wr(0, 12'h000, 8'h30);
    n = 0;
    while (!erased[7] && n < 2 * ERASE_CYC) begin
      @(negedge clk);
      n++;
    end
    chk(n < ERASE_CYC - 2, "R9 resume keeps progress", n, ERASE_CYC - 2);
    bus_wr(0, 12'h000, 8'hB0);
    snap = erased;
    cyc(60);
    chk(erased == snap, "R9 stable in second suspend", erased, snap);
    bus_wr(0, 12'h000, 8'h30);
    wait_ready(1000);
    cyc(2);
    chk(erased == 16'h1088, "R10 protected sector skipped", erased, 16'h1088);

    // R11 chip erase ignores suspend
    push_mask(~prot_mask);
    unlock5();
    bus_wr(0, 12'h555, 8'h10);
    cyc(20);
    bus_wr(0, 12'h000, 8'hB0);
    cyc(5);
    chk(ready == 1'b0, "R11 suspend ignored in chip erase", ready, 0);
    wait_ready(2000);
    cyc(2);
    chk(erased == ~prot_mask, "R11 chip erase mask", erased, ~prot_mask);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule